// File: doc/BRIEF.md
# Multi-Mode Video Pixel Port Formatter

This block takes decoded video samples and lays them out on a 20-pin output pixel port. Each pin has its own output enable, so pins that the selected layout does not use are released to high impedance. Input samples are either 4:2:2 luma/chroma at up to 10 bits (one luma sample per pixel, with the Cb and Cr of a pixel pair both presented), or 8-bit-per-channel RGB. A three-bit format select picks one of five pin layouts: an 8-bit or 10-bit interleaved 4:2:2 stream, a 16-bit or 20-bit side-by-side 4:2:2 bus, or a 12-bit RGB bus that carries each pixel as two half-words, one per clock edge of the downstream pixel clock.

The block runs from one clock at twice the pixel rate and exposes a phase bit. A pixel slot is two clocks long: inputs are taken on the edge at which the phase bit is 0, the slot's first word is on the pins during the following clock, and its second word during the clock after that. In the interleaved layouts the first word is the chroma sample and the second the luma sample; in the two-edge RGB layout the first word is the rising-phase word and the second the falling-phase word; the side-by-side layouts hold one word for the whole slot. The interleaved layouts can also carry embedded timing reference codes, which take two slots each.

A new format select takes effect only at a line start, and while no valid data is offered the whole port is released.

Top module: `vid_pixel_port_fmt`

## Requirements
- R1: While `rst_n` is low, `pix_o`, `pix_oe_o` and `phase_o` are all zero, and the active format is "off" (every pin released) until the first line start.
- R2: `phase_o` toggles on every clock after reset. Inputs are taken on the edge where `phase_o` is 0. The slot's first word shows on the pins for the next clock, and its second word for the clock after that.
- R3: `fmt_sel_i` is copied into the active format only on a slot edge with `line_start_i` high. That slot already uses the new format. The codes are 0 = interleaved 8-bit, 1 = interleaved 10-bit, 2 = side-by-side 16-bit, 3 = side-by-side 20-bit, 4 = two-edge RGB, and 5 to 7 = off (all pins released).
- R4: Interleaved 8-bit: the first word carries the chroma sample and the second the luma sample, with sample bits 9..2 on pins 19..12. Only pins 19..12 are enabled.
- R5: Interleaved 10-bit: the same word order as R4, with the full 10-bit sample on pins 19..10. Only pins 19..10 are enabled.
- R6: Chroma alternates Cb, Cr, Cb, ... over valid pixels. It restarts at Cb after a line start and after a start-of-active code (horizontal flag 0). The result is the word order Cb, Y, Cr, Y.
- R7: In the interleaved formats, `tc_req_i` on a slot edge emits the four words full-scale, zero, zero, status over that slot and the next. Full-scale is all ones on the enabled pins. During the second slot, `in_valid_i` and `tc_req_i` are ignored. In these formats a code request wins over a valid pixel in the same slot.
- R8: The status word is, MSB first: 1, F, V, H, V^H, F^H, F^V, F^V^H. In 10-bit mode it sits on pins 19..12, and pins 11..10 are 0.
- R9: Side-by-side 16-bit: luma bits 9..2 on pins 19..12 and chroma bits 9..2 on pins 9..2, held for both words. Pins 11, 10, 1 and 0 are released.
- R10: Side-by-side 20-bit: luma on pins 19..10 and chroma on pins 9..0, held for both words. All pins are enabled.
- R11: Two-edge RGB: the first word has B[7:0] on pins 19..12 and G[3:0] on pins 9..6. The second word has R[3:0] on pins 19..16, G[7:4] on pins 15..12 and R[7:4] on pins 9..6. Pins 11, 10 and 5..0 are released in both words.
- R12: A slot with nothing to send (no valid pixel, no code, or format off) releases every pin for both words. A released pin always drives 0, and the enables stay constant across the two words of a slot.
- R13: In the side-by-side and RGB formats, `tc_req_i` has no effect: a valid pixel in the same slot is sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel_i | input | 3 | Requested pin layout (R3 codes) |
| line_start_i | input | 1 | Line start marker, taken on slot edges |
| in_valid_i | input | 1 | Pixel present in this slot |
| in_y_i | input | 10 | Luma sample |
| in_cb_i | input | 10 | Cb sample of the pixel pair |
| in_cr_i | input | 10 | Cr sample of the pixel pair |
| in_r_i | input | 8 | Red sample |
| in_g_i | input | 8 | Green sample |
| in_b_i | input | 8 | Blue sample |
| tc_req_i | input | 1 | Request a timing reference code in this slot |
| tc_field_i | input | 1 | Field flag F of the code |
| tc_vblank_i | input | 1 | Vertical blanking flag V of the code |
| tc_h_i | input | 1 | Horizontal flag H: 1 end of active, 0 start of active |
| phase_o | output | 1 | Slot phase; inputs taken where it is 0 |
| pix_o | output | 20 | Pixel port data |
| pix_oe_o | output | 20 | Per-pin output enable |

## Verification
The bench targets the points where a layout is easy to get subtly wrong. In the RGB split, one swapped nibble of green or red shows as a wrong value on pins 15..12 or 9..6 of one half-word. A format select that takes effect mid-line would change the enable pattern before the line marker. A chroma phase that fails to restart at a start-of-active code would emit Cr where Cb is due. A pixel offered during the second half of a timing code, if not ignored, would overwrite the zero or status word. The 10-bit status word is checked for its two trailing zero bits. Code requests are driven with valid pixels in the side-by-side formats, where a design that honoured them would replace the pixel with full-scale.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  localparam int PIN_W    = 20;
  localparam int SMP_W    = 10;
  localparam int RGB_W    = 8;
  localparam int NARROW_W = 8;
  localparam int STAT_W   = 8;

  typedef enum logic [2:0] {
    M_ITL8  = 3'd0,
    M_ITL10 = 3'd1,
    M_PAR16 = 3'd2,
    M_PAR20 = 3'd3,
    M_RGB12 = 3'd4,
    M_OFF   = 3'd7
  } fmt_e;

  typedef enum logic [1:0] {
    K_IDLE,
    K_PIX,
    K_CODE_A,
    K_CODE_B
  } slot_e;

  typedef struct packed {
    logic [PIN_W-1:0] dat;
    logic [PIN_W-1:0] oe;
  } pinword_t;

  function automatic fmt_e decode_fmt(input logic [2:0] raw);
    case (raw)
      3'd0:    return M_ITL8;
      3'd1:    return M_ITL10;
      3'd2:    return M_PAR16;
      3'd3:    return M_PAR20;
      3'd4:    return M_RGB12;
      default: return M_OFF;
    endcase
  endfunction

  function automatic logic is_itl(input fmt_e m);
    return (m == M_ITL8) || (m == M_ITL10);
  endfunction

  // Status word of a timing reference code with its protection bits.
  function automatic logic [STAT_W-1:0] tc_status(input logic f, input logic v, input logic h);
    logic [3:0] prot;
    prot = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return {1'b1, f, v, h, prot};
  endfunction

  function automatic logic [PIN_W-1:0] pin_mask(input fmt_e m);
    case (m)
      M_ITL8:  return 20'hFF000;
      M_ITL10: return 20'hFFC00;
      M_PAR16: return 20'hFF3FC;
      M_PAR20: return 20'hFFFFF;
      M_RGB12: return 20'hFF3C0;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PIN_W-1:0] place_itl(input fmt_e m, input logic [SMP_W-1:0] s);
    if (m == M_ITL10) return {s, {(PIN_W-SMP_W){1'b0}}};
    return {s[SMP_W-1 -: NARROW_W], {(PIN_W-NARROW_W){1'b0}}};
  endfunction

  function automatic logic [PIN_W-1:0] place_par(input fmt_e m, input logic [SMP_W-1:0] y,
                                                  input logic [SMP_W-1:0] c);
    if (m == M_PAR20) return {y, c};
    return {y[SMP_W-1 -: NARROW_W], 2'b00, c[SMP_W-1 -: NARROW_W], 2'b00};
  endfunction

  function automatic logic [PIN_W-1:0] rgb_rise(input logic [RGB_W-1:0] g, input logic [RGB_W-1:0] b);
    return {b, 2'b00, g[3:0], 6'b0};
  endfunction

  function automatic logic [PIN_W-1:0] rgb_fall(input logic [RGB_W-1:0] r, input logic [RGB_W-1:0] g);
    return {r[3:0], g[7:4], 2'b00, r[7:4], 6'b0};
  endfunction

endpackage

// File: rtl/vpf_slot_seq.sv
module vpf_slot_seq
  import vpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fmt_raw_i,
  input  logic        line_start_i,
  input  logic        in_valid_i,
  input  logic        tc_req_i,
  input  logic        tc_f_i,
  input  logic        tc_v_i,
  input  logic        tc_h_i,
  output logic        phase_o,
  output logic        take_o,
  output fmt_e        eff_fmt_o,
  output fmt_e        held_fmt_o,
  output slot_e       kind_o,
  output logic        use_cr_o,
  output logic [STAT_W-1:0] code_stat_o,
  output logic        code_a_fire_o
);

  logic              phase_q;
  fmt_e              fmt_q;
  logic              par_q;
  logic              pend_q;
  logic [STAT_W-1:0] pend_stat_q;
  logic              par_clr;
  logic              itl;

  assign phase_o     = phase_q;
  assign take_o      = ~phase_q;
  assign held_fmt_o  = fmt_q;
  assign code_stat_o = pend_stat_q;

  always_comb begin
    eff_fmt_o = (take_o && line_start_i) ? decode_fmt(fmt_raw_i) : fmt_q;
    itl       = is_itl(eff_fmt_o);
    if (pend_q && itl)                     kind_o = K_CODE_B;
    else if (tc_req_i && itl)              kind_o = K_CODE_A;
    else if (in_valid_i && eff_fmt_o != M_OFF) kind_o = K_PIX;
    else                                   kind_o = K_IDLE;
    par_clr       = line_start_i || (kind_o == K_CODE_A && !tc_h_i);
    use_cr_o      = par_clr ? 1'b0 : par_q;
    code_a_fire_o = take_o && (kind_o == K_CODE_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= 1'b0;
      fmt_q       <= M_OFF;
      par_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_stat_q <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (take_o) begin
        fmt_q  <= eff_fmt_o;
        pend_q <= (kind_o == K_CODE_A);
        if (kind_o == K_CODE_A) pend_stat_q <= tc_status(tc_f_i, tc_v_i, tc_h_i);
        par_q  <= (kind_o == K_PIX) ? ~use_cr_o : use_cr_o;
      end
    end
  end

endmodule

// File: rtl/vpf_word_build.sv
module vpf_word_build
  import vpf_pkg::*;
(
  input  slot_e             kind_i,
  input  fmt_e              fmt_i,
  input  logic              use_cr_i,
  input  logic [SMP_W-1:0]  y_i,
  input  logic [SMP_W-1:0]  cb_i,
  input  logic [SMP_W-1:0]  cr_i,
  input  logic [RGB_W-1:0]  r_i,
  input  logic [RGB_W-1:0]  g_i,
  input  logic [RGB_W-1:0]  b_i,
  input  logic [STAT_W-1:0] code_stat_i,
  output pinword_t          w_first_o,
  output pinword_t          w_second_o
);

  logic [PIN_W-1:0] mask;
  logic [SMP_W-1:0] chroma;

  always_comb begin
    mask       = pin_mask(fmt_i);
    chroma     = use_cr_i ? cr_i : cb_i;
    w_first_o  = '0;
    w_second_o = '0;
    case (kind_i)
      K_PIX: begin
        w_first_o.oe  = mask;
        w_second_o.oe = mask;
        case (fmt_i)
          M_ITL8, M_ITL10: begin
            w_first_o.dat  = place_itl(fmt_i, chroma);
            w_second_o.dat = place_itl(fmt_i, y_i);
          end
          M_PAR16, M_PAR20: begin
            w_first_o.dat  = place_par(fmt_i, y_i, chroma);
            w_second_o.dat = place_par(fmt_i, y_i, chroma);
          end
          M_RGB12: begin
            w_first_o.dat  = rgb_rise(g_i, b_i);
            w_second_o.dat = rgb_fall(r_i, g_i);
          end
          default: begin
            w_first_o  = '0;
            w_second_o = '0;
          end
        endcase
      end
      K_CODE_A: begin
        w_first_o.oe   = mask;
        w_second_o.oe  = mask;
        w_first_o.dat  = place_itl(fmt_i, {SMP_W{1'b1}});
      end
      K_CODE_B: begin
        w_first_o.oe   = mask;
        w_second_o.oe  = mask;
        w_second_o.dat = place_itl(fmt_i, {code_stat_i, 2'b00});
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/vpf_out_stage.sv
module vpf_out_stage
  import vpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  pinword_t         w_first_i,
  input  pinword_t         w_second_i,
  output logic [PIN_W-1:0] pix_o,
  output logic [PIN_W-1:0] oe_o
);

  pinword_t out_q;
  pinword_t hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      hold_q <= '0;
    end else if (take_i) begin
      out_q  <= w_first_i;
      hold_q <= w_second_i;
    end else begin
      out_q  <= hold_q;
    end
  end

  assign pix_o = out_q.dat;
  assign oe_o  = out_q.oe;

endmodule

// File: rtl/vid_pixel_port_fmt.sv
module vid_pixel_port_fmt
  import vpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fmt_sel_i,
  input  logic        line_start_i,
  input  logic        in_valid_i,
  input  logic [9:0]  in_y_i,
  input  logic [9:0]  in_cb_i,
  input  logic [9:0]  in_cr_i,
  input  logic [7:0]  in_r_i,
  input  logic [7:0]  in_g_i,
  input  logic [7:0]  in_b_i,
  input  logic        tc_req_i,
  input  logic        tc_field_i,
  input  logic        tc_vblank_i,
  input  logic        tc_h_i,
  output logic        phase_o,
  output logic [19:0] pix_o,
  output logic [19:0] pix_oe_o
);

  logic              take;
  fmt_e              act_fmt;
  fmt_e              held_fmt;
  slot_e             slot_kind;
  logic              use_cr;
  logic [STAT_W-1:0] code_stat;
  logic              code_a_fire;
  logic [2:0]        mode_held_bits;
  pinword_t          w_first;
  pinword_t          w_second;

  assign mode_held_bits = held_fmt;

  vpf_slot_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_raw_i    (fmt_sel_i),
    .line_start_i (line_start_i),
    .in_valid_i   (in_valid_i),
    .tc_req_i     (tc_req_i),
    .tc_f_i       (tc_field_i),
    .tc_v_i       (tc_vblank_i),
    .tc_h_i       (tc_h_i),
    .phase_o      (phase_o),
    .take_o       (take),
    .eff_fmt_o    (act_fmt),
    .held_fmt_o   (held_fmt),
    .kind_o       (slot_kind),
    .use_cr_o     (use_cr),
    .code_stat_o  (code_stat),
    .code_a_fire_o(code_a_fire)
  );

  vpf_word_build u_build (
    .kind_i      (slot_kind),
    .fmt_i       (act_fmt),
    .use_cr_i    (use_cr),
    .y_i         (in_y_i),
    .cb_i        (in_cb_i),
    .cr_i        (in_cr_i),
    .r_i         (in_r_i),
    .g_i         (in_g_i),
    .b_i         (in_b_i),
    .code_stat_i (code_stat),
    .w_first_o   (w_first),
    .w_second_o  (w_second)
  );

  vpf_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .w_first_i  (w_first),
    .w_second_i (w_second),
    .pix_o      (pix_o),
    .oe_o       (pix_oe_o)
  );

endmodule

// File: rtl/vpf_fmt_chk.sv
module vpf_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phase_o,
  input logic [19:0] pix_o,
  input logic [19:0] pix_oe_o,
  input logic [2:0]  mode_held,
  input logic        line_start_i,
  input logic        code_a_fire
);

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_o != $past(phase_o)));

  assert_released_pins_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_o & ~pix_oe_o) == 20'h0);

  assert_oe_steady_in_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 1'b0) |-> $stable(pix_oe_o));

  assert_mode_at_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_held != $past(mode_held)) |-> $past(line_start_i && !phase_o));

  assert_ddr_released_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_held == 3'd4) |-> ((pix_oe_o & 20'h00C3F) == 20'h0));

  assert_code_full_scale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_a_fire |=> (pix_o[19:12] == 8'hFF));

endmodule

bind vid_pixel_port_fmt vpf_fmt_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase_o      (phase_o),
  .pix_o        (pix_o),
  .pix_oe_o     (pix_oe_o),
  .mode_held    (mode_held_bits),
  .line_start_i (line_start_i),
  .code_a_fire  (code_a_fire)
);

// File: tb/vid_pixel_port_fmt_test.sv
module vid_pixel_port_fmt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel_i = 3'd7;
  logic        line_start_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [9:0]  in_y_i = '0, in_cb_i = '0, in_cr_i = '0;
  logic [7:0]  in_r_i = '0, in_g_i = '0, in_b_i = '0;
  logic        tc_req_i = 1'b0, tc_field_i = 1'b0, tc_vblank_i = 1'b0, tc_h_i = 1'b0;
  logic        phase_o;
  logic [19:0] pix_o, pix_oe_o;

  always #10 clk = ~clk;

  vid_pixel_port_fmt uut (.*);

  typedef struct {
    logic [19:0] d;
    logic [19:0] e;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t got;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  int  m_mode = -1;   // -1 = off
  bit  m_cr = 1'b0;
  bit  m_pend = 1'b0;
  logic [7:0] m_stat = '0;

  task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] put(input logic [19:0] w, input int lo, input int n,
                                      input logic [9:0] v, input int vlo);
    logic [19:0] r = w;
    for (int k = 0; k < n; k++) r[lo+k] = v[vlo+k];
    return r;
  endfunction

  function automatic logic [19:0] mask_of(input int m);
    logic [19:0] w = '0;
    case (m)
      0: w = put(w, 12, 8, 10'h3FF, 0);
      1: w = put(w, 10, 10, 10'h3FF, 0);
      2: begin w = put(w, 12, 8, 10'h3FF, 0); w = put(w, 2, 8, 10'h3FF, 0); end
      3: begin w = put(w, 10, 10, 10'h3FF, 0); w = put(w, 0, 10, 10'h3FF, 0); end
      4: begin w = put(w, 12, 8, 10'h3FF, 0); w = put(w, 6, 4, 10'h3FF, 0); end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [19:0] itl_word(input int m, input logic [9:0] s);
    if (m == 0) return put('0, 12, 8, s, 2);
    return put('0, 10, 10, s, 0);
  endfunction

  task automatic push(input logic [19:0] d, input logic [19:0] e, input string tag);
    exp_t x;
    x.d = d; x.e = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic slot(input bit vld, input bit ls, input logic [2:0] sel,
                      input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr,
                      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                      input bit tc, input bit f, input bit v, input bit h, input string tag);
    bit itl, was_pend;
    logic [19:0] mk, d0, d1;
    logic [9:0] c;
    @(negedge clk);
    while (phase_o !== 1'b0) @(negedge clk);
    in_valid_i = vld; line_start_i = ls; fmt_sel_i = sel;
    in_y_i = y; in_cb_i = cb; in_cr_i = cr; in_r_i = r; in_g_i = g; in_b_i = b;
    tc_req_i = tc; tc_field_i = f; tc_vblank_i = v; tc_h_i = h;
    if (ls) m_mode = (sel <= 3'd4) ? int'(sel) : -1;
    itl = (m_mode == 0) || (m_mode == 1);
    mk = mask_of(m_mode);
    was_pend = m_pend;
    m_pend = 1'b0;
    if (ls) m_cr = 1'b0;
    if (was_pend && itl) begin
      push('0, mk, tag);
      push(itl_word(m_mode, {m_stat, 2'b00}), mk, tag);
    end else if (tc && itl) begin
      m_pend = 1'b1;
      m_stat = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      if (!h) m_cr = 1'b0;
      push(itl_word(m_mode, 10'h3FF), mk, tag);
      push('0, mk, tag);
    end else if (vld && m_mode >= 0) begin
      c = m_cr ? cr : cb;
      m_cr = ~m_cr;
      case (m_mode)
        0, 1: begin d0 = itl_word(m_mode, c); d1 = itl_word(m_mode, y); end
        2: begin d0 = put(put('0, 12, 8, y, 2), 2, 8, c, 2); d1 = d0; end
        3: begin d0 = put(put('0, 10, 10, y, 0), 0, 10, c, 0); d1 = d0; end
        default: begin
          d0 = put(put('0, 12, 8, {2'b00, b}, 0), 6, 4, {2'b00, g}, 0);
          d1 = put(put(put('0, 16, 4, {2'b00, r}, 0), 12, 4, {2'b00, g}, 4), 6, 4, {2'b00, r}, 4);
        end
      endcase
      push(d0, mk, tag);
      push(d1, mk, tag);
    end else begin
      push('0, '0, tag);
      push('0, '0, tag);
    end
  endtask

  task automatic pix(input logic [2:0] sel, input logic [9:0] y, input logic [9:0] cb,
                     input logic [9:0] cr, input string tag);
    slot(1'b1, 1'b0, sel, y, cb, cr, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic code(input bit ls, input logic [2:0] sel, input bit f, input bit v,
                      input bit h, input string tag);
    slot(1'b0, ls, sel, '0, '0, '0, '0, '0, '0, 1'b1, f, v, h, tag);
  endtask

  task automatic rgb(input logic [2:0] sel, input logic [7:0] r, input logic [7:0] g,
                     input logic [7:0] b, input string tag);
    slot(1'b1, 1'b0, sel, '0, '0, '0, r, g, b, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: one expected word per clock after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      got = q.pop_front();
      chk(pix_o === got.d, {got.tag, " data"}, pix_o, got.d);
      chk(pix_oe_o === got.e, {got.tag, " oe"}, pix_oe_o, got.e);
    end
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic p1, p2;
    repeat (3) @(negedge clk);
    chk(pix_o === 20'h0, "R1 reset data", pix_o, 20'h0);
    chk(pix_oe_o === 20'h0, "R1 reset oe", pix_oe_o, 20'h0);
    chk({19'h0, phase_o} === 20'h0, "R1 reset phase", {19'h0, phase_o}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk); p1 = phase_o;
    @(negedge clk); p2 = phase_o;
    chk(p1 != p2, "R2 phase toggle", {19'h0, p2}, {19'h0, ~p1});

    // R3: valid pixels before any line start: format is off
    pix(3'd0, 10'h155, 10'h2AA, 10'h0F3, "R3 off before line start");
    pix(3'd0, 10'h156, 10'h2AB, 10'h0F4, "R3 off before line start");

    // R4 R6 R7 R8: 8-bit interleaved line
    code(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R7 R8 start code 8-bit");
    slot(1'b1, 1'b0, 3'd0, 10'h3C3, 10'h111, 10'h222, '0, '0, '0, 1'b1, 1'b1, 1'b1, 1'b1,
         "R7 second half ignores inputs");
    pix(3'd0, 10'h1A4, 10'h2C8, 10'h0F0, "R4 R6 first pixel Cb");
    pix(3'd0, 10'h1A8, 10'h2C8, 10'h0F0, "R4 R6 second pixel Cr");
    pix(3'd0, 10'h3FC, 10'h004, 10'h3F8, "R4 R6 third pixel Cb");
    pix(3'd3, 10'h123, 10'h040, 10'h380, "R3 select ignored mid-line");
    code(1'b0, 3'd3, 1'b1, 1'b1, 1'b1, "R7 R8 end code");
    pix(3'd3, 10'h000, 10'h000, 10'h000, "R7 code second half");

    // R5 R6 R8: 10-bit interleaved, parity restart at start code
    code(1'b1, 3'd1, 1'b1, 1'b0, 1'b0, "R5 R8 start code 10-bit");
    pix(3'd1, 10'h000, 10'h000, 10'h000, "R7 code second half 10-bit");
    pix(3'd1, 10'h2D7, 10'h13B, 10'h3C5, "R5 R6 Cb");
    code(1'b0, 3'd1, 1'b0, 1'b1, 1'b0, "R6 R8 mid-line start code");
    pix(3'd1, 10'h000, 10'h000, 10'h000, "R7 code second half");
    pix(3'd1, 10'h0A1, 10'h1B2, 10'h2C3, "R6 Cb after start code");
    pix(3'd1, 10'h0A2, 10'h1B2, 10'h2C3, "R6 Cr follows");
    slot(1'b0, 1'b0, 3'd1, '0, '0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R12 idle 10-bit");

    // R9 R13: 16-bit side-by-side, code request has no effect
    slot(1'b1, 1'b1, 3'd2, 10'h2F1, 10'h1E5, 10'h0D9, '0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0,
         "R9 R13 16-bit with code request");
    pix(3'd2, 10'h3A7, 10'h1E5, 10'h0D9, "R9 16-bit Cr");
    slot(1'b0, 1'b0, 3'd2, '0, '0, '0, '0, '0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R13 R12 code alone idle");

    // R10: 20-bit side-by-side
    slot(1'b1, 1'b1, 3'd3, 10'h3FF, 10'h001, 10'h200, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0,
         "R10 20-bit Cb");
    pix(3'd3, 10'h155, 10'h001, 10'h2AA, "R10 20-bit Cr");

    // R11: two-edge RGB
    slot(1'b1, 1'b1, 3'd4, '0, '0, '0, 8'hA5, 8'h3C, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 RGB a");
    rgb(3'd4, 8'h12, 8'hC7, 8'h0E, "R11 RGB b");
    rgb(3'd4, 8'hFF, 8'h00, 8'h81, "R11 RGB c");
    slot(1'b0, 1'b0, 3'd4, '0, '0, '0, '0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R12 R13 RGB idle");

    // R3: reserved code turns the port off
    slot(1'b1, 1'b1, 3'd6, 10'h111, 10'h222, 10'h333, 8'h44, 8'h55, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0,
         "R3 reserved code off");
    pix(3'd6, 10'h111, 10'h222, 10'h333, "R3 R12 off stays released");

    @(negedge clk);
    in_valid_i = 1'b0; tc_req_i = 1'b0; line_start_i = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule